// File: doc/BRIEF.md
# Interrupt Line Router for One CPU Interface

This block is the last stage of one CPU's interrupt interface. Arbitration logic upstream picks the highest-priority pending interrupt for the CPU and offers it on a valid/ready post channel. The router reads the interrupt's group bit from a bank of 32-bit group words and combines it with the CPU's fast-interrupt enable. From the two it decides which of the CPU's two request lines to drive: the fast line (`fiq_o`) or the normal line (`irq_o`). The line rises after a programmable latency. The router remembers the interrupt it signalled and the line it chose for it. Any later clear drops exactly that line.

Two events clear a signalled interrupt. One is an acknowledge read, which returns the interrupt ID with its source CPU, or the spurious ID when nothing is held. The other is a level-drop notice for a level-sensitive interrupt that is no longer pending. Each returns the stored state to spurious.

Post channel rules: a post is accepted on a clock edge where `post_valid` and `post_ready` are both high. `post_ready` goes low on the cycle after acceptance and stays low until the latency countdown has expired. A source may hold `post_valid` high through that window. Nothing it offers there is taken, and the offer is only accepted once `post_ready` returns.

Top module: `irq_line_router`

## Requirements
- R1: On firing, the fast line is driven when the interrupt's group bit is 1 (group 0) and the `fiq_en` value captured at acceptance is 1. In every other case the normal line is driven.
- R2: The group bit for an ID is bit (ID mod 32) of word (ID >> 5). Word w occupies `group_words[32w+31:32w]`. An ID whose word lies outside the bank is treated as group 1.
- R3: When both `en_grp0` and `en_grp1` are low at a firing, the post is dropped and no line rises. From the cycle after both enables are low, both lines are low.
- R4: A post accepted at edge k with latency L asserts its line after edge k+1+L. The line is low before that.
- R5: `post_ready` is low from the cycle after acceptance until the firing edge. A post offered in that window is not taken and does not change what fires.
- R6: An acknowledge read (`ack_rd` high for one edge) while an interrupt is held gives `ack_vld` high in the next cycle. `ack_data` then holds the ID in [9:0], the source CPU in [12:10] and zeros in [31:13]. The held interrupt becomes spurious and its line drops.
- R7: An acknowledge read with no held interrupt returns `ack_data` = 1023.
- R8: `lvl_drop` clears the line and the held interrupt when the held interrupt is level-sensitive. For an edge-triggered held interrupt it has no effect.
- R9: The two lines are never high together. A new firing replaces the previous interrupt and its line.
- R10: With `rst_n` low at a clock edge, both lines drop, any countdown is cancelled, `ack_vld` is 0 and the held interrupt becomes spurious.
- R11: A clear drops the line that was driven for the interrupt, even if `fiq_en` has changed since.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_grp0 | input | 1 | CPU interface group-0 enable |
| en_grp1 | input | 1 | CPU interface group-1 enable |
| fiq_en | input | 1 | Route group-0 interrupts to the fast line |
| lat_cycles | input | LAT_W | Posting latency, sampled at acceptance |
| group_words | input | 32*ceil(NUM_IRQ/32) | Group bank, 1 = group 0 |
| post_valid | input | 1 | Post offer valid |
| post_ready | output | 1 | Router can accept a post |
| post_id | input | 10 | Offered interrupt ID |
| post_src | input | 3 | Offered source CPU ID |
| post_level | input | 1 | Offered interrupt is level-sensitive |
| ack_rd | input | 1 | Acknowledge read strobe |
| ack_vld | output | 1 | Acknowledge result valid |
| ack_data | output | 32 | Acknowledge result |
| lvl_drop | input | 1 | Held level interrupt no longer pending |
| fiq_o | output | 1 | Fast interrupt request line |
| irq_o | output | 1 | Normal interrupt request line |

## Verification
The bench covers every combination of group bit and fast enable over IDs at the word edges (0, 31, 32, 63). A wrong word or bit index would route an interrupt from its neighbour's group bit, and a wrong routing term would raise the other line. It changes `fiq_en` between posting and acknowledge. A design that recomputes the route at clear time would then leave the fast line stuck high. It offers a second post during the countdown and counts the exact rising cycle for several latencies. A restartable timer would fire late or fire the wrong ID, and an off-by-one counter would move the edge. It also sends a level-drop for edge-triggered interrupts, which must leave the line standing.

// File: rtl/irq_rt_pkg.sv
package irq_rt_pkg;
  localparam int unsigned ID_W   = 10;
  localparam int unsigned CPU_W  = 3;
  localparam int unsigned ACK_W  = 32;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned BIT_SEL_W = $clog2(WORD_W);
  localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

  typedef struct packed {
    logic [ID_W-1:0]  id;
    logic [CPU_W-1:0] src;
    logic             level;
    logic             to_fiq;
  } irq_rec_t;
endpackage

// File: rtl/irq_group_lookup.sv
module irq_group_lookup
  import irq_rt_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 64
) (
  input  logic [((NUM_IRQ+WORD_W-1)/WORD_W)*WORD_W-1:0] group_words,
  input  logic [ID_W-1:0]                               id,
  output logic                                          is_grp0
);
  localparam int unsigned N_WORDS = (NUM_IRQ + WORD_W - 1) / WORD_W;
  localparam int unsigned WSEL_W  = ID_W - BIT_SEL_W;

  logic [WORD_W-1:0]    word_arr [N_WORDS];
  logic [WSEL_W-1:0]    widx;
  logic [BIT_SEL_W-1:0] bidx;

  for (genvar g = 0; g < N_WORDS; g++) begin : g_word
    assign word_arr[g] = group_words[g*WORD_W +: WORD_W];
  end

  assign widx = id[ID_W-1:BIT_SEL_W];
  assign bidx = id[BIT_SEL_W-1:0];

  // Words outside the bank read as group 1.
  always_comb begin
    is_grp0 = 1'b0;
    for (int w = 0; w < N_WORDS; w++) begin
      if (widx == WSEL_W'(w)) is_grp0 = word_arr[w][bidx];
    end
  end
endmodule

// File: rtl/irq_post_timer.sv
module irq_post_timer
  import irq_rt_pkg::*;
#(
  parameter int unsigned LAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  irq_rec_t         in_rec,
  input  logic [LAT_W-1:0] lat,
  output logic             fire,
  output irq_rec_t         fire_rec
);
  logic             busy_q;
  logic [LAT_W-1:0] cnt_q;
  irq_rec_t         rec_q;

  assign in_ready = !busy_q;
  assign fire     = busy_q && (cnt_q == '0);
  assign fire_rec = rec_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      rec_q  <= '0;
    end else if (in_valid && in_ready) begin
      busy_q <= 1'b1;
      cnt_q  <= lat;
      rec_q  <= in_rec;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/irq_line_ctrl.sv
module irq_line_ctrl
  import irq_rt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_en,
  input  logic             fire,
  input  irq_rec_t         fire_rec,
  input  logic             ack_rd,
  input  logic             lvl_drop,
  output logic             fiq_o,
  output logic             irq_o,
  output logic             ack_vld,
  output logic [ACK_W-1:0] ack_data
);
  localparam int unsigned PAD_W = ACK_W - ID_W - CPU_W;

  irq_rec_t cur_q;
  logic     held;

  assign held = (cur_q.id != SPURIOUS_ID);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fiq_o     <= 1'b0;
      irq_o     <= 1'b0;
      ack_vld   <= 1'b0;
      ack_data  <= '0;
      cur_q     <= '0;
      cur_q.id  <= SPURIOUS_ID;
    end else begin
      ack_vld <= ack_rd;
      if (ack_rd) begin
        if (held) begin
          ack_data <= {{PAD_W{1'b0}}, cur_q.src, cur_q.id};
          cur_q.id <= SPURIOUS_ID;
          if (cur_q.to_fiq) fiq_o <= 1'b0;
          else              irq_o <= 1'b0;
        end else begin
          ack_data <= {{(ACK_W-ID_W){1'b0}}, SPURIOUS_ID};
        end
      end else if (lvl_drop && held && cur_q.level) begin
        cur_q.id <= SPURIOUS_ID;
        if (cur_q.to_fiq) fiq_o <= 1'b0;
        else              irq_o <= 1'b0;
      end
      // A firing overrides any clear in the same cycle.
      if (fire && cpu_en) begin
        cur_q <= fire_rec;
        fiq_o <= fire_rec.to_fiq;
        irq_o <= !fire_rec.to_fiq;
      end
      if (!cpu_en) begin
        fiq_o <= 1'b0;
        irq_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_line_router.sv
module irq_line_router
  import irq_rt_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 64,
  parameter int unsigned LAT_W   = 8,
  localparam int unsigned GW_W   = ((NUM_IRQ + WORD_W - 1) / WORD_W) * WORD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_grp0,
  input  logic             en_grp1,
  input  logic             fiq_en,
  input  logic [LAT_W-1:0] lat_cycles,
  input  logic [GW_W-1:0]  group_words,
  input  logic             post_valid,
  output logic             post_ready,
  input  logic [ID_W-1:0]  post_id,
  input  logic [CPU_W-1:0] post_src,
  input  logic             post_level,
  input  logic             ack_rd,
  output logic             ack_vld,
  output logic [ACK_W-1:0] ack_data,
  input  logic             lvl_drop,
  output logic             fiq_o,
  output logic             irq_o
);
  logic     grp0;
  logic     cpu_en;
  logic     fire_w;
  irq_rec_t in_rec;
  irq_rec_t fire_rec;

  assign cpu_en = en_grp0 || en_grp1;

  irq_group_lookup #(.NUM_IRQ(NUM_IRQ)) u_lookup (
    .group_words (group_words),
    .id          (post_id),
    .is_grp0     (grp0)
  );

  always_comb begin
    in_rec.id     = post_id;
    in_rec.src    = post_src;
    in_rec.level  = post_level;
    in_rec.to_fiq = grp0 && fiq_en;
  end

  irq_post_timer #(.LAT_W(LAT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (post_valid),
    .in_ready (post_ready),
    .in_rec   (in_rec),
    .lat      (lat_cycles),
    .fire     (fire_w),
    .fire_rec (fire_rec)
  );

  irq_line_ctrl u_lines (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_en   (cpu_en),
    .fire     (fire_w),
    .fire_rec (fire_rec),
    .ack_rd   (ack_rd),
    .lvl_drop (lvl_drop),
    .fiq_o    (fiq_o),
    .irq_o    (irq_o),
    .ack_vld  (ack_vld),
    .ack_data (ack_data)
  );
endmodule

// File: rtl/irq_line_router_chk.sv
module irq_line_router_chk
  import irq_rt_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             en_grp0,
  input logic             en_grp1,
  input logic             post_valid,
  input logic             post_ready,
  input logic             fire,
  input logic             ack_rd,
  input logic             ack_vld,
  input logic [ACK_W-1:0] ack_data,
  input logic             fiq_o,
  input logic             irq_o
);
  // R9
  one_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fiq_o && irq_o));

  // R3
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_grp0 && !en_grp1) |=> (!fiq_o && !irq_o));

  // R5
  hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (post_valid && post_ready) |=> !post_ready);

  // R6
  ack_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_rd |=> ack_vld);

  // R6
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && !fire) |=> (!fiq_o && !irq_o));

  // R6
  ack_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_vld |-> (ack_data[ACK_W-1:ID_W+CPU_W] == '0));

  // R7
  spur_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_vld && ack_data[ID_W-1:0] == SPURIOUS_ID) |-> (ack_data[ACK_W-1:ID_W] == '0));
endmodule

bind irq_line_router irq_line_router_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en_grp0    (en_grp0),
  .en_grp1    (en_grp1),
  .post_valid (post_valid),
  .post_ready (post_ready),
  .fire       (fire_w),
  .ack_rd     (ack_rd),
  .ack_vld    (ack_vld),
  .ack_data   (ack_data),
  .fiq_o      (fiq_o),
  .irq_o      (irq_o)
);

// File: tb/test_irq_line_router.sv
module test_irq_line_router;
  localparam int NUM_IRQ = 64;
  localparam int LAT_W   = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        en_grp0, en_grp1, fiq_en;
  logic [7:0]  lat_cycles;
  logic [63:0] group_words;
  logic        post_valid, post_ready, post_level;
  logic [9:0]  post_id;
  logic [2:0]  post_src;
  logic        ack_rd, ack_vld, lvl_drop, fiq_o, irq_o;
  logic [31:0] ack_data;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  irq_line_router #(.NUM_IRQ(NUM_IRQ), .LAT_W(LAT_W)) i_irq_line_router (
    .clk(clk), .rst_n(rst_n), .en_grp0(en_grp0), .en_grp1(en_grp1),
    .fiq_en(fiq_en), .lat_cycles(lat_cycles), .group_words(group_words),
    .post_valid(post_valid), .post_ready(post_ready), .post_id(post_id),
    .post_src(post_src), .post_level(post_level), .ack_rd(ack_rd),
    .ack_vld(ack_vld), .ack_data(ack_data), .lvl_drop(lvl_drop),
    .fiq_o(fiq_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the negedge after the accepting edge.
  task automatic do_post(input logic [9:0] id, input logic [2:0] src, input logic lvl);
    post_valid = 1'b1; post_id = id; post_src = src; post_level = lvl;
    @(posedge clk); @(negedge clk);
    post_valid = 1'b0;
  endtask

  task automatic wait_fire(input int lat);
    repeat (lat + 1) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_ack();
    ack_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    ack_rd = 1'b0;
  endtask

  function automatic logic [31:0] ack_word(input logic [9:0] id, input logic [2:0] src);
    return {19'd0, src, id};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [9:0] ids [8] = '{10'd0, 10'd1, 10'd5, 10'd31, 10'd32, 10'd33, 10'd47, 10'd63};
    logic       exp_f;
    rst_n = 1'b0; en_grp0 = 1'b1; en_grp1 = 1'b0; fiq_en = 1'b0;
    lat_cycles = 8'd0; group_words = '0; post_valid = 1'b0; post_id = '0;
    post_src = '0; post_level = 1'b0; ack_rd = 1'b0; lvl_drop = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    check("R10 fiq", 32'(fiq_o), 0);
    check("R10 irq", 32'(irq_o), 0);
    check("R10 ack_vld", 32'(ack_vld), 0);
    check("R10 ready", 32'(post_ready), 1);
    // R7 spurious after reset
    do_ack();
    check("R7 vld", 32'(ack_vld), 1);
    check("R7 data", ack_data, 32'd1023);

    // R1 R2 R6 sweep
    for (int i = 0; i < 8; i++) begin
      for (int g = 0; g < 2; g++) begin
        for (int fe = 0; fe < 2; fe++) begin
          group_words = (g == 1) ? (64'd1 << ids[i]) : ~(64'd1 << ids[i]);
          fiq_en = fe[0];
          exp_f = g[0] & fe[0];
          do_post(ids[i], ids[i][2:0], 1'b0);
          wait_fire(0);
          check("R1 fiq", 32'(fiq_o), 32'(exp_f));
          check("R2 irq", 32'(irq_o), 32'(!exp_f));
          do_ack();
          check("R6 data", ack_data, ack_word(ids[i], ids[i][2:0]));
          check("R6 lines", 32'({fiq_o, irq_o}), 0);
        end
      end
    end

    // R2 ID outside bank is group 1
    group_words = '1; fiq_en = 1'b1;
    do_post(10'd100, 3'd6, 1'b0);
    wait_fire(0);
    check("R2 outside bank irq", 32'({fiq_o, irq_o}), 32'b01);
    do_ack();
    check("R6 outside data", ack_data, ack_word(10'd100, 3'd6));

    // R4 R5 latency
    for (int l = 1; l <= 5; l += 2) begin
      lat_cycles = 8'(l);
      do_post(10'd9, 3'd1, 1'b0);
      if (l == 5) begin post_valid = 1'b1; post_id = 10'd7; post_src = 3'd2; end
      for (int c = 1; c <= l; c++) begin
        @(posedge clk); @(negedge clk);
        if (c == l) post_valid = 1'b0;
        check("R4 low before", 32'({fiq_o, irq_o}), 0);
        check("R5 ready low", 32'(post_ready), 0);
      end
      @(posedge clk); @(negedge clk);
      check("R4 fires", 32'({fiq_o, irq_o}), 32'b10);
      do_ack();
      check("R5 first kept", ack_data, ack_word(10'd9, 3'd1));
    end
    lat_cycles = 8'd0;

    // R3 disabled interface
    en_grp0 = 1'b0; en_grp1 = 1'b0;
    do_post(10'd3, 3'd0, 1'b0);
    wait_fire(0);
    check("R3 no line", 32'({fiq_o, irq_o}), 0);
    do_ack();
    check("R3 dropped", ack_data, 32'd1023);
    en_grp1 = 1'b1;
    do_post(10'd4, 3'd0, 1'b0);
    wait_fire(0);
    check("R3 grp1 enables", 32'({fiq_o, irq_o}), 32'b10);
    en_grp1 = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R3 lines drop", 32'({fiq_o, irq_o}), 0);
    en_grp0 = 1'b1;
    do_ack();

    // R8 level drop
    do_post(10'd12, 3'd3, 1'b1);
    wait_fire(0);
    lvl_drop = 1'b1; @(posedge clk); @(negedge clk); lvl_drop = 1'b0;
    check("R8 level cleared", 32'({fiq_o, irq_o}), 0);
    do_ack();
    check("R8 level spurious", ack_data, 32'd1023);
    group_words = '0;
    do_post(10'd13, 3'd3, 1'b0);
    wait_fire(0);
    lvl_drop = 1'b1; @(posedge clk); @(negedge clk); lvl_drop = 1'b0;
    check("R8 edge kept", 32'({fiq_o, irq_o}), 32'b01);
    do_ack();
    check("R8 edge data", ack_data, ack_word(10'd13, 3'd3));

    // R9 replacement
    group_words = 64'd1 << 20; fiq_en = 1'b1;
    do_post(10'd20, 3'd4, 1'b0);
    wait_fire(0);
    check("R9 first fast", 32'({fiq_o, irq_o}), 32'b10);
    do_post(10'd21, 3'd5, 1'b0);
    wait_fire(0);
    check("R9 replaced", 32'({fiq_o, irq_o}), 32'b01);
    do_ack();
    check("R9 newest acked", ack_data, ack_word(10'd21, 3'd5));

    // R11 clear follows the driven line
    do_post(10'd20, 3'd7, 1'b0);
    wait_fire(0);
    fiq_en = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R11 still fast", 32'({fiq_o, irq_o}), 32'b10);
    do_ack();
    check("R11 cleared", 32'({fiq_o, irq_o}), 0);
    check("R11 data", ack_data, ack_word(10'd20, 3'd7));

    // R10 reset cancels countdown
    lat_cycles = 8'd4;
    do_post(10'd22, 3'd0, 1'b0);
    rst_n = 1'b0; @(posedge clk); @(negedge clk); rst_n = 1'b1;
    repeat (6) @(posedge clk);
    @(negedge clk);
    check("R10 cancelled", 32'({fiq_o, irq_o}), 0);
    check("R10 ready", 32'(post_ready), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule